// File: doc/BRIEF.md
# Burst Ring-Buffer Memory Writer

This block runs in the memory clock domain (166 MHz in the target system, faster than the 125 MHz sample stream) and empties a first-word-fall-through sample FIFO into a self-refreshing DRAM. Samples are not written as a continuous stream. The block waits until the FIFO holds at least one full burst and the memory reports itself free. It then issues a single write command and moves exactly one burst of words. After that it stays quiet for a minimum number of cycles, so the memory can refresh or take control traffic.

The write address always points at the start of the next burst. It advances by one burst length per burst. When it reaches the end of memory it returns to zero, which turns the memory into a ring buffer. A one-cycle pulse marks each return to zero. A held register gives the address of the newest word written, so a readout controller can find the most recent data. A sticky flag records that the FIFO ever reached a high-water mark. Such a level means the burst rate is at risk of falling behind the sample rate.

Top module: `burst_ring_writer`

## Requirements
- R1: While reset is asserted (rstN low) and in the first cycle after it, cmdValid, wrValid, fifoRd, wrapPulse and underrunRisk are 0, and cmdAddr and lastAddr are 0.
- R2: A write command (cmdValid high for exactly one cycle) is issued only when fifoLevel is at least BURST_LEN and memBusy was low in the cycle that allowed it. No command is issued while memBusy stays high.
- R3: The cycle after a command starts exactly BURST_LEN consecutive beats. In each beat wrValid and fifoRd are both 1 and wrData equals the FIFO head word, so words leave in FIFO order. memBusy raised during a burst does not shorten it.
- R4: After the last beat of a burst, at least GAP_MIN cycles with neither cmdValid nor wrValid pass before the next command.
- R5: cmdAddr starts at 0 and advances by BURST_LEN after each burst. It returns to 0 after the burst that ends at word MEM_WORDS-1.
- R6: wrapPulse is high for exactly one cycle, the cycle after the last beat of the burst that returns the address to 0, and is 0 at all other times.
- R7: In the cycle after a burst's last beat, lastAddr equals that burst's start address plus BURST_LEN-1. It holds that value until the next burst ends.
- R8: underrunRisk becomes 1 once fifoLevel has been at or above HIGH_WATER at a clock edge. It stays 1 until reset.
- R9: With fifoLevel below BURST_LEN, no command is issued and no word is read, so the remainder stays in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoData | input | DATA_W | FIFO head word (first-word-fall-through) |
| fifoLevel | input | LVL_W | Number of words held in the FIFO |
| fifoRd | output | 1 | Pop strobe, one word per cycle |
| memBusy | input | 1 | Memory refreshing or otherwise unavailable |
| cmdValid | output | 1 | One-cycle burst write command |
| cmdAddr | output | ADDR_W | Start address of the next burst |
| wrValid | output | 1 | Write beat valid |
| wrData | output | DATA_W | Write beat data |
| wrapPulse | output | 1 | Address returned to zero |
| lastAddr | output | ADDR_W | Address of the newest word written |
| underrunRisk | output | 1 | Sticky high-water flag |

## Verification
A table of fill patterns is applied. A level that stays just under one burst shows that nothing moves early. A top-up to exactly one burst shows the threshold. A fill of several bursts that leaves a remainder shows repeated bursts with the remainder left behind. A burst-ready level held back by memBusy shows that the command waits. A long steady stream that outruns the drain rate separates the sticky flag from a flag that only follows the level. Directed cases then raise memBusy in the middle of a burst, carry the address across the end of memory, and apply reset after the flag has been set. Throughout, a running monitor compares every beat's data, every command address, the gap length and the newest-word address with a model kept in the bench.

// File: rtl/burst_writer_pkg.sv
package burst_writer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_READY,
    ST_CMD,
    ST_DATA,
    ST_GAP
  } wrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issueCmd;
    logic moveBeat;
    logic gapTick;
  } wrStrobe_t;

endpackage

// File: rtl/bw_control.sv
module bw_control
  import burst_writer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      levelOk,
  input  logic      memBusy,
  input  logic      beatLast,
  input  logic      gapDone,
  output wrStrobe_t strb,
  output logic      inCmd,
  output logic      inData
);

  wrState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:       if (levelOk)  stateNext = ST_WAIT_READY;
      ST_WAIT_READY: if (!memBusy) stateNext = ST_CMD;
      ST_CMD:                      stateNext = ST_DATA;
      ST_DATA:       if (beatLast) stateNext = ST_GAP;
      ST_GAP:        if (gapDone)  stateNext = ST_IDLE;
      default:                     stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.issueCmd = (state == ST_CMD);
    strb.moveBeat = (state == ST_DATA);
    strb.gapTick  = (state == ST_GAP);
  end

  assign inCmd  = (state == ST_CMD);
  assign inData = (state == ST_DATA);

endmodule

// File: rtl/bw_datapath.sv
module bw_datapath
  import burst_writer_pkg::*;
#(
  parameter int LVL_W      = 6,
  parameter int BURST_LEN  = 8,
  parameter int MEM_WORDS  = 64,
  parameter int GAP_MIN    = 3,
  parameter int HIGH_WATER = 16,
  localparam int ADDR_W    = $clog2(MEM_WORDS),
  localparam int BEAT_W    = $clog2(BURST_LEN + 1),
  localparam int GAP_W     = $clog2(GAP_MIN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  logic [LVL_W-1:0]  fifoLevel,
  output logic              levelOk,
  output logic              beatLast,
  output logic              gapDone,
  output logic [ADDR_W-1:0] writeAddr,
  output logic [ADDR_W-1:0] lastAddr,
  output logic              wrapPulse,
  output logic              underrunRisk
);

  localparam logic [ADDR_W-1:0] LAST_BASE = ADDR_W'(MEM_WORDS - BURST_LEN);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(BURST_LEN);

  logic [BEAT_W-1:0] beatCnt;
  logic [GAP_W-1:0]  gapCnt;

  assign levelOk  = fifoLevel >= LVL_W'(BURST_LEN);
  assign beatLast = strb.moveBeat && (beatCnt == BEAT_W'(BURST_LEN - 1));
  assign gapDone  = strb.gapTick && (gapCnt == GAP_W'(GAP_MIN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt <= '0;
    end else if (strb.issueCmd) begin
      beatCnt <= '0;
    end else if (strb.moveBeat) begin
      beatCnt <= beatCnt + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (beatLast) begin
      gapCnt <= '0;
    end else if (strb.gapTick) begin
      gapCnt <= gapCnt + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeAddr <= '0;
      lastAddr  <= '0;
      wrapPulse <= 1'b0;
    end else begin
      wrapPulse <= 1'b0;
      if (beatLast) begin
        lastAddr <= writeAddr + STEP - ADDR_W'(1);
        if (writeAddr == LAST_BASE) begin
          writeAddr <= '0;
          wrapPulse <= 1'b1;
        end else begin
          writeAddr <= writeAddr + STEP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) underrunRisk <= 1'b0;
    else if (fifoLevel >= LVL_W'(HIGH_WATER)) underrunRisk <= 1'b1;
  end

endmodule

// File: rtl/burst_ring_writer.sv
module burst_ring_writer
  import burst_writer_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int LVL_W      = 6,
  parameter int BURST_LEN  = 8,
  parameter int MEM_WORDS  = 64,
  parameter int GAP_MIN    = 3,
  parameter int HIGH_WATER = 16,
  localparam int ADDR_W    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] fifoData,
  input  logic [LVL_W-1:0]  fifoLevel,
  output logic              fifoRd,
  input  logic              memBusy,
  output logic              cmdValid,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              wrValid,
  output logic [DATA_W-1:0] wrData,
  output logic              wrapPulse,
  output logic [ADDR_W-1:0] lastAddr,
  output logic              underrunRisk
);

  wrStrobe_t strb;
  logic levelOk, beatLast, gapDone, inCmd, inData;

  bw_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .levelOk  (levelOk),
    .memBusy  (memBusy),
    .beatLast (beatLast),
    .gapDone  (gapDone),
    .strb     (strb),
    .inCmd    (inCmd),
    .inData   (inData)
  );

  bw_datapath #(
    .LVL_W      (LVL_W),
    .BURST_LEN  (BURST_LEN),
    .MEM_WORDS  (MEM_WORDS),
    .GAP_MIN    (GAP_MIN),
    .HIGH_WATER (HIGH_WATER)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .fifoLevel    (fifoLevel),
    .levelOk      (levelOk),
    .beatLast     (beatLast),
    .gapDone      (gapDone),
    .writeAddr    (cmdAddr),
    .lastAddr     (lastAddr),
    .wrapPulse    (wrapPulse),
    .underrunRisk (underrunRisk)
  );

  assign cmdValid = inCmd;
  assign wrValid  = inData;
  assign fifoRd   = inData;
  assign wrData   = fifoData;

endmodule

// File: rtl/bw_checker.sv
module bw_checker #(
  parameter int LVL_W     = 6,
  parameter int BURST_LEN = 8,
  parameter int ADDR_W    = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic              memBusy,
  input logic              cmdValid,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              wrValid,
  input logic              fifoRd,
  input logic              wrapPulse,
  input logic              underrunRisk
);

  assert_cmd_needs_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> fifoLevel >= LVL_W'(BURST_LEN));

  assert_cmd_after_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !$past(memBusy));

  assert_cmd_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_cmd_then_beat_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (wrValid && fifoRd));

  assert_beat_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrValid) |-> $past(cmdValid));

  assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> cmdAddr == '0);

  assert_wrap_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> !wrapPulse);

  assert_risk_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(underrunRisk) |-> underrunRisk);

endmodule

bind burst_ring_writer bw_checker #(
  .LVL_W     (LVL_W),
  .BURST_LEN (BURST_LEN),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .fifoLevel    (fifoLevel),
  .memBusy      (memBusy),
  .cmdValid     (cmdValid),
  .cmdAddr      (cmdAddr),
  .wrValid      (wrValid),
  .fifoRd       (fifoRd),
  .wrapPulse    (wrapPulse),
  .underrunRisk (underrunRisk)
);

// File: tb/tb_burst_ring_writer.sv
`timescale 1ns/1ps
module tb_burst_ring_writer;

  localparam int DATA_W = 16, LVL_W = 6, BL = 8, MEMW = 64, GAPM = 3, HW = 16;
  localparam int ADDR_W = $clog2(MEMW);

  // pushes, busyCycles, runCycles, expBursts, expResidual, expRisk
  localparam int NVEC = 5;
  localparam int VEC [NVEC][6] = '{
    '{ 5,  0,  60, 0, 5, 0},
    '{ 3,  0,  60, 1, 0, 0},
    '{20,  0, 120, 2, 4, 0},
    '{ 4, 10,  80, 1, 0, 0},
    '{40,  0, 200, 5, 0, 1}
  };

  logic clk = 0, rstN = 0;
  logic [DATA_W-1:0] fifoData = '0;
  logic [LVL_W-1:0]  fifoLevel = '0;
  logic memBusy = 0;
  logic fifoRd, cmdValid, wrValid, wrapPulse, underrunRisk;
  logic [ADDR_W-1:0] cmdAddr, lastAddr;
  logic [DATA_W-1:0] wrData;

  always #5 clk = ~clk;

  burst_ring_writer dut (
    .clk(clk), .rstN(rstN), .fifoData(fifoData), .fifoLevel(fifoLevel),
    .fifoRd(fifoRd), .memBusy(memBusy), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .wrValid(wrValid), .wrData(wrData), .wrapPulse(wrapPulse),
    .lastAddr(lastAddr), .underrunRisk(underrunRisk)
  );

  int nChecks = 0, nFails = 0;
  int pushIdx = 0, popIdx = 0;
  int expAddr = 0, expData = 0, beatCnt = 0, gapCnt = 100;
  int bursts = 0, cmdCount = 0, wrapCount = 0;
  bit prevValid = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // runs at the negative edge: compares outputs with the bench model
  task automatic monitor();
    bit ended;
    bit expWrap;
    check(fifoRd == wrValid, "R3 fifoRd/wrValid", int'(fifoRd), int'(wrValid));
    if (cmdValid) begin
      check(int'(cmdAddr) == expAddr, "R5 cmdAddr", int'(cmdAddr), expAddr);
      check(gapCnt >= GAPM, "R4 gap", gapCnt, GAPM);
      beatCnt = 0;
      cmdCount++;
    end
    if (wrValid) begin
      check(int'(wrData) == (expData & 16'hFFFF), "R3 data order", int'(wrData), expData);
      expData++;
      beatCnt++;
      gapCnt = 0;
    end
    ended = prevValid && !wrValid;
    if (ended) begin
      check(beatCnt == BL, "R3 beats", beatCnt, BL);
      check(int'(lastAddr) == expAddr + BL - 1, "R7 lastAddr", int'(lastAddr), expAddr + BL - 1);
      expWrap = (expAddr + BL == MEMW);
      check(wrapPulse == expWrap, "R6 wrapPulse", int'(wrapPulse), int'(expWrap));
      if (wrapPulse) wrapCount++;
      expAddr = expWrap ? 0 : expAddr + BL;
      bursts++;
    end else begin
      check(!wrapPulse, "R6 stray wrapPulse", int'(wrapPulse), 0);
    end
    if (!wrValid && !cmdValid) gapCnt++;
    prevValid = wrValid;
  endtask

  task automatic stepCycle(input bit doPush, input bit busyVal);
    bit rd;
    @(negedge clk);
    monitor();
    rd = fifoRd;
    @(posedge clk);
    #1;
    if (rd) popIdx++;
    if (doPush) pushIdx++;
    memBusy   = busyVal;
    fifoLevel = LVL_W'(pushIdx - popIdx);
    fifoData  = DATA_W'(popIdx);
  endtask

  task automatic checkResetState(input string tag);
    check(!cmdValid && !wrValid && !fifoRd, {tag, " strobes"}, int'({cmdValid, wrValid, fifoRd}), 0);
    check(cmdAddr == '0 && lastAddr == '0, {tag, " addresses"}, int'(cmdAddr) + int'(lastAddr), 0);
    check(!wrapPulse && !underrunRisk, {tag, " flags"}, int'({wrapPulse, underrunRisk}), 0);
  endtask

  initial begin
    #(10 * 20000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    checkResetState("R1 in reset");
    rstN = 1;
    @(negedge clk);
    checkResetState("R1 after reset");

    // table of fill patterns (R2, R8, R9)
    for (int v = 0; v < NVEC; v++) begin
      int b0, c0;
      b0 = bursts;
      c0 = cmdCount;
      for (int c = 0; c < VEC[v][2]; c++) begin
        stepCycle(c < VEC[v][0], c < VEC[v][1]);
        if (VEC[v][1] > 0 && c == VEC[v][1] - 1)
          check(cmdCount == c0, "R2 no command while busy", cmdCount - c0, 0);
      end
      check(bursts - b0 == VEC[v][3], "R2/R9 burst count", bursts - b0, VEC[v][3]);
      check(pushIdx - popIdx == VEC[v][4], "R9 residual level", pushIdx - popIdx, VEC[v][4]);
      check(int'(underrunRisk) == VEC[v][5], "R8 underrunRisk", int'(underrunRisk), VEC[v][5]);
    end

    // R3: busy raised in the middle of a burst is ignored
    begin
      int b0, c0;
      b0 = bursts;
      c0 = cmdCount;
      for (int c = 0; c < 40 && cmdCount == c0; c++) stepCycle(c < BL, 1'b0);
      for (int c = 0; c < 4; c++) stepCycle(1'b0, 1'b1);
      for (int c = 0; c < 30; c++) stepCycle(1'b0, 1'b0);
      check(bursts - b0 == 1, "R3 burst completes under busy", bursts - b0, 1);
      check(pushIdx == popIdx, "R3 all words drained", pushIdx - popIdx, 0);
    end

    // R5/R6: ten bursts so far, exactly one ring wrap
    check(bursts == 10, "R5 total bursts", bursts, 10);
    check(wrapCount == 1, "R6 wrap count", wrapCount, 1);
    check(int'(cmdAddr) == 2 * BL, "R5 address after wrap", int'(cmdAddr), 2 * BL);

    // R8: sticky flag stays set with an empty FIFO, cleared only by reset
    stepCycle(1'b0, 1'b0);
    check(underrunRisk == 1'b1, "R8 sticky while level low", int'(underrunRisk), 1);
    @(posedge clk);
    #1;
    rstN = 0;
    #2;
    checkResetState("R1/R8 reset clears");
    @(posedge clk);
    #1;
    rstN = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule